// File: doc/BRIEF.md
# Four-Bank SDRAM Command Sequencer

This block sits on the controller side of a double-data-rate SDRAM with four banks. It turns simple user requests into the SDRAM command stream. Each request names a bank, a row, a column, a direction and an optional close-after-burst flag. The block drives the active-low chip select, row strobe, column strobe and write enable lines, the 2-bit bank address and a 12-bit address bus. All of these are registered on the rising clock edge.

The block remembers which row is open in each bank, and each bank is tracked on its own. A request that hits the open row goes straight to its column command. A request that finds a different row open first closes that bank. A request to an idle bank opens the row first. A refresh timer raises a pending flag at a programmable interval. At the next decision point that flag wins over user traffic: open banks are closed together, then an Auto Refresh is issued.

Programmable gaps set the minimum spacing between commands: activate to column, precharge to next command, refresh to next command, and the burst length. The user holds a request until a one-cycle accept pulse appears. That pulse comes out together with the column command that serves the request.

Top module: `sdcmd_seq`

## Requirements
- R1: After reset, and in every cycle with no command, the outputs show deselect (`cs_n`, `ras_n`, `cas_n`, `we_n` all 1) and `req_accept` is 0.
- R2: The command codes on {cs_n,ras_n,cas_n,we_n} are: activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001.
- R3: A request to an idle bank produces an activate carrying the bank on `ba` and the row on `addr`. The column command follows exactly `cfg_t_rcd` cycles later.
- R4: A request to the row already open in its bank produces the column command directly, with no activate. It carries the column on `addr[8:0]`, the close flag on `addr[10]`, and 0 on `addr[9]` and `addr[11]`.
- R5: A request to a bank with another row open produces a precharge of that bank with `addr[10]`=0. An activate of the new row follows exactly `cfg_t_rp` cycles later, then the column command.
- R6: Each of the four banks keeps its open row independently. Opening a row in one bank does not disturb the hit status of another bank.
- R7: A column command with the close flag set leaves its bank idle, so the next access to that bank needs an activate. The next command comes no sooner than burst gap plus `cfg_t_rp` cycles after the column command.
- R8: `cfg_burst` codes 1, 2 and 3 select burst lengths 2, 4 and 8. Consecutive column commands are spaced exactly burst-length/2 cycles apart.
- R9: At each refresh interval an auto refresh is issued. If any bank is open, it is preceded by a precharge with `addr[10]`=1 exactly `cfg_t_rp` cycles earlier. The next command comes exactly `cfg_t_rfc` cycles after the refresh, and all banks are idle afterwards.
- R10: When a refresh is pending and a user request waits at the same decision point, the refresh sequence is issued first.
- R11: `req_accept` is high only in the cycle where the column command for the held request is shown, and only if `req_valid` was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Target row |
| req_col | input | 9 | Starting column |
| req_autopre | input | 1 | Close the bank after this burst |
| cfg_burst | input | 2 | Burst length code (1:2, 2:4, 3:8) |
| cfg_t_rcd | input | 4 | Activate to column gap, cycles |
| cfg_t_rp | input | 4 | Precharge to next command gap, cycles |
| cfg_t_rfc | input | 4 | Refresh to next command gap, cycles |
| cfg_ref_interval | input | 16 | Cycles between refresh requests |
| req_accept | output | 1 | One-cycle accept pulse |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Row, column and close flag |

## Verification
The bench drives a row miss after a hit in the same bank. A design that compared rows without the per-bank open bit, or read another bank's row, would skip the precharge or activate again needlessly. It issues a close-flag read and then re-accesses the same row. A sequencer that forgot to clear the bank would give a bare column command to a closed bank, or would come too early. It lines up a pending refresh against a waiting request while a long burst gap drains. Losing the priority shows up as a column command before the all-bank precharge. A second refresh with every bank idle must not emit a useless precharge. Exact spacing is measured for all three burst codes and for every timing gap.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_DESEL = 4'b1111,
        CMD_ACT   = 4'b0011,
        CMD_RD    = 4'b0101,
        CMD_WR    = 4'b0100,
        CMD_PRE   = 4'b0010,
        CMD_REF   = 4'b0001
    } cmd_e;

    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int ADDR_W    = 12;
    localparam int COL_W     = 9;
    localparam int AP_BIT    = 10;

    typedef struct packed {
        logic              write;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] row;
        logic [COL_W-1:0]  col;
        logic              autopre;
    } req_t;

    // Cycles occupied by one burst on a double-rate bus
    function automatic logic [2:0] burst_gap(input logic [1:0] code);
        case (code)
            2'd1:    burst_gap = 3'd1;
            2'd3:    burst_gap = 3'd4;
            default: burst_gap = 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/sdcmd_bank_table.sv
module sdcmd_bank_table #(
    parameter int NB    = 4,
    parameter int ROW_W = 12,
    localparam int SEL_W = $clog2(NB)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      open_en,
    input  logic                      close_en,
    input  logic                      close_all,
    input  logic [SEL_W-1:0]          sel,
    input  logic [ROW_W-1:0]          row_in,
    output logic [NB-1:0]             open_q,
    output logic [NB-1:0][ROW_W-1:0]  row_q
);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (close_all || (close_en && sel == SEL_W'(b))) begin
                open_q[b] <= 1'b0;
            end else if (open_en && sel == SEL_W'(b)) begin
                open_q[b] <= 1'b1;
                row_q[b]  <= row_in;
            end
        end
    end

endmodule

// File: rtl/sdcmd_gap_timer.sv
module sdcmd_gap_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] gap,
    output logic         busy
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= (gap == '0) ? '0 : gap - W'(1);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/sdcmd_refresh_timer.sv
module sdcmd_refresh_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] interval,
    input  logic         ack,
    output logic         pending
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else if (ack) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else if (cnt >= interval - W'(1)) begin
            cnt     <= '0;
            pending <= 1'b1;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
    import sdcmd_pkg::*;
#(
    parameter int T_W   = 4,
    parameter int REF_W = 16,
    localparam int LV_W = T_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [BANK_W-1:0]   req_bank,
    input  logic [ADDR_W-1:0]   req_row,
    input  logic [COL_W-1:0]    req_col,
    input  logic                req_autopre,
    input  logic [1:0]          cfg_burst,
    input  logic [T_W-1:0]      cfg_t_rcd,
    input  logic [T_W-1:0]      cfg_t_rp,
    input  logic [T_W-1:0]      cfg_t_rfc,
    input  logic [REF_W-1:0]    cfg_ref_interval,
    output logic                req_accept,
    output logic                cs_n,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [BANK_W-1:0]   ba,
    output logic [ADDR_W-1:0]   addr
);

    req_t                                  req;
    cmd_e                                  nxt_cmd;
    logic [BANK_W-1:0]                     nxt_ba;
    logic [ADDR_W-1:0]                     nxt_addr;
    logic                                  nxt_acc;
    logic [LV_W-1:0]                       nxt_gap;
    logic                                  busy, ref_pending, ref_ack;
    logic                                  tb_open, tb_close, tb_close_all;
    logic [NUM_BANKS-1:0]                  open_q;
    logic [NUM_BANKS-1:0][ADDR_W-1:0]      row_q;
    logic                                  hit;

    assign req = '{write: req_write, bank: req_bank, row: req_row,
                   col: req_col, autopre: req_autopre};

    assign hit = open_q[req.bank] && (row_q[req.bank] == req.row);

    always_comb begin
        nxt_cmd      = CMD_DESEL;
        nxt_ba       = '0;
        nxt_addr     = '0;
        nxt_acc      = 1'b0;
        nxt_gap      = '0;
        tb_open      = 1'b0;
        tb_close     = 1'b0;
        tb_close_all = 1'b0;
        ref_ack      = 1'b0;
        if (!busy) begin
            if (ref_pending) begin
                if (|open_q) begin
                    nxt_cmd          = CMD_PRE;
                    nxt_addr[AP_BIT] = 1'b1;
                    tb_close_all     = 1'b1;
                    nxt_gap          = LV_W'(cfg_t_rp);
                end else begin
                    nxt_cmd = CMD_REF;
                    ref_ack = 1'b1;
                    nxt_gap = LV_W'(cfg_t_rfc);
                end
            end else if (req_valid) begin
                nxt_ba = req.bank;
                if (hit) begin
                    nxt_cmd                = req.write ? CMD_WR : CMD_RD;
                    nxt_addr[COL_W-1:0]    = req.col;
                    nxt_addr[AP_BIT]       = req.autopre;
                    nxt_acc                = 1'b1;
                    tb_close               = req.autopre;
                    nxt_gap                = LV_W'(burst_gap(cfg_burst))
                                           + (req.autopre ? LV_W'(cfg_t_rp) : '0);
                end else if (open_q[req.bank]) begin
                    nxt_cmd  = CMD_PRE;
                    tb_close = 1'b1;
                    nxt_gap  = LV_W'(cfg_t_rp);
                end else begin
                    nxt_cmd  = CMD_ACT;
                    nxt_addr = req.row;
                    tb_open  = 1'b1;
                    nxt_gap  = LV_W'(cfg_t_rcd);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            {cs_n, ras_n, cas_n, we_n} <= CMD_DESEL;
            ba         <= '0;
            addr       <= '0;
            req_accept <= 1'b0;
        end else begin
            {cs_n, ras_n, cas_n, we_n} <= nxt_cmd;
            ba         <= nxt_ba;
            addr       <= nxt_addr;
            req_accept <= nxt_acc;
        end
    end

    sdcmd_bank_table #(.NB(NUM_BANKS), .ROW_W(ADDR_W)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .open_en   (tb_open),
        .close_en  (tb_close),
        .close_all (tb_close_all),
        .sel       (req.bank),
        .row_in    (req.row),
        .open_q    (open_q),
        .row_q     (row_q)
    );

    sdcmd_gap_timer #(.W(LV_W)) u_gap (
        .clk  (clk),
        .rst  (rst),
        .load (nxt_cmd != CMD_DESEL),
        .gap  (nxt_gap),
        .busy (busy)
    );

    sdcmd_refresh_timer #(.W(REF_W)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .interval (cfg_ref_interval),
        .ack      (ref_ack),
        .pending  (ref_pending)
    );

endmodule

// File: rtl/sdcmd_seq_chk.sv
module sdcmd_seq_chk #(
    parameter int T_W = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           req_valid,
    input logic           req_accept,
    input logic           cs_n,
    input logic           ras_n,
    input logic           cas_n,
    input logic           we_n,
    input logic [T_W-1:0] cfg_t_rcd,
    input logic [T_W-1:0] cfg_t_rp,
    input logic [T_W-1:0] cfg_t_rfc
);

    logic [3:0] cmd;
    logic       is_act, is_col, is_pre, is_ref, is_any;
    logic [7:0] since_act, since_pre, since_ref;

    assign cmd    = {cs_n, ras_n, cas_n, we_n};
    assign is_act = (cmd == 4'b0011);
    assign is_pre = (cmd == 4'b0010);
    assign is_ref = (cmd == 4'b0001);
    assign is_col = (cmd == 4'b0101) || (cmd == 4'b0100);
    assign is_any = !cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= 8'hFF;
            since_pre <= 8'hFF;
            since_ref <= 8'hFF;
        end else begin
            since_act <= is_act ? 8'd1 : (since_act == 8'hFF ? since_act : since_act + 8'd1);
            since_pre <= is_pre ? 8'd1 : (since_pre == 8'hFF ? since_pre : since_pre + 8'd1);
            since_ref <= is_ref ? 8'd1 : (since_ref == 8'hFF ? since_ref : since_ref + 8'd1);
        end
    end

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (ras_n && cas_n && we_n && !req_accept)); // R1

    AST_RCD_GAP: assert property (@(posedge clk) disable iff (rst)
        is_col |-> (since_act >= 8'(cfg_t_rcd))); // R3

    AST_RP_GAP: assert property (@(posedge clk) disable iff (rst)
        (is_act || is_ref) |-> (since_pre >= 8'(cfg_t_rp))); // R5

    AST_RFC_GAP: assert property (@(posedge clk) disable iff (rst)
        is_any |-> (since_ref >= 8'(cfg_t_rfc))); // R9

    AST_ACCEPT_WITH_COL: assert property (@(posedge clk) disable iff (rst)
        req_accept |-> (is_col && $past(req_valid))); // R11

endmodule

bind sdcmd_seq sdcmd_seq_chk #(.T_W(T_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_accept (req_accept),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .cfg_t_rcd  (cfg_t_rcd),
    .cfg_t_rp   (cfg_t_rp),
    .cfg_t_rfc  (cfg_t_rfc)
);

// File: tb/sdcmd_seq_tb.sv
module sdcmd_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LOGN = 256;

    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic        req_autopre = 1'b0;
    logic [1:0]  cfg_burst = 2'd2;
    logic [3:0]  cfg_t_rcd = 4'd3;
    logic [3:0]  cfg_t_rp = 4'd2;
    logic [3:0]  cfg_t_rfc = 4'd5;
    logic [15:0] cfg_ref_interval = 16'd60000;
    logic        req_accept, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int acc_cyc = 0;
    int n_log = 0;
    int n_ref = 0;
    logic [3:0]  lg_cmd  [LOGN];
    logic [1:0]  lg_ba   [LOGN];
    logic [11:0] lg_addr [LOGN];
    int          lg_cyc  [LOGN];

    sdcmd_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_autopre(req_autopre), .cfg_burst(cfg_burst), .cfg_t_rcd(cfg_t_rcd),
        .cfg_t_rp(cfg_t_rp), .cfg_t_rfc(cfg_t_rfc), .cfg_ref_interval(cfg_ref_interval),
        .req_accept(req_accept), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && !cs_n && n_log < LOGN) begin
            lg_cmd[n_log]  <= {cs_n, ras_n, cas_n, we_n};
            lg_ba[n_log]   <= ba;
            lg_addr[n_log] <= addr;
            lg_cyc[n_log]  <= cyc;
            n_log <= n_log + 1;
            if ({cs_n, ras_n, cas_n, we_n} == C_REF) n_ref <= n_ref + 1;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", rq, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic do_req(input bit wr, input logic [1:0] b, input logic [11:0] r,
                          input logic [8:0] c, input bit ap);
        bit got = 0;
        req_valid = 1'b1; req_write = wr; req_bank = b;
        req_row = r; req_col = c; req_autopre = ap;
        for (int i = 0; i < 200 && !got; i++) begin
            @(negedge clk);
            if (req_accept) begin
                got = 1;
                acc_cyc = cyc;
            end
        end
        req_valid = 1'b0;
        chk(got, "R11 accept seen", int'(got), 1);
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        int base = n_log;
        repeat (4) @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} == 4'hF, "R1 deselect after reset",
            int'({cs_n, ras_n, cas_n, we_n}), 15);
        chk(!req_accept, "R1 accept low", int'(req_accept), 0);
        chk(n_log == base, "R1 no command when idle", n_log - base, 0);
    endtask

    task automatic t_closed_bank();
        int base = n_log;
        do_req(1'b1, 2'd0, 12'd5, 9'd8, 1'b0);
        @(negedge clk);
        chk(lg_cmd[base] == C_ACT, "R2 activate code", int'(lg_cmd[base]), int'(C_ACT));
        chk(lg_addr[base] == 12'd5 && lg_ba[base] == 2'd0, "R3 activate row/bank",
            int'(lg_addr[base]), 5);
        chk(lg_cmd[base+1] == C_WR, "R2 write code", int'(lg_cmd[base+1]), int'(C_WR));
        chk(lg_cyc[base+1] - lg_cyc[base] == 3, "R3 rcd gap",
            lg_cyc[base+1] - lg_cyc[base], 3);
        chk(acc_cyc == lg_cyc[base+1], "R11 accept with column", acc_cyc, lg_cyc[base+1]);
        settle();
    endtask

    task automatic t_hit();
        int base = n_log;
        do_req(1'b0, 2'd0, 12'd5, 9'd16, 1'b0);
        settle();
        chk(n_log - base == 1, "R4 hit single command", n_log - base, 1);
        chk(lg_cmd[base] == C_RD, "R2 read code", int'(lg_cmd[base]), int'(C_RD));
        chk(lg_addr[base] == 12'd16, "R4 column address", int'(lg_addr[base]), 16);
    endtask

    task automatic t_miss();
        int base = n_log;
        do_req(1'b0, 2'd0, 12'd7, 9'd1, 1'b0);
        settle();
        chk(lg_cmd[base] == C_PRE && lg_addr[base][10] == 1'b0 && lg_ba[base] == 2'd0,
            "R5 single precharge", int'(lg_cmd[base]), int'(C_PRE));
        chk(lg_cmd[base+1] == C_ACT && lg_addr[base+1] == 12'd7, "R5 activate new row",
            int'(lg_addr[base+1]), 7);
        chk(lg_cyc[base+1] - lg_cyc[base] == 2, "R5 rp gap",
            lg_cyc[base+1] - lg_cyc[base], 2);
        chk(lg_cmd[base+2] == C_RD && lg_addr[base+2] == 12'd1, "R5 column after",
            int'(lg_addr[base+2]), 1);
    endtask

    task automatic t_banks();
        int base = n_log;
        do_req(1'b0, 2'd1, 12'd9, 9'd2, 1'b0);
        settle();
        chk(lg_cmd[base] == C_ACT && lg_ba[base] == 2'd1, "R6 open bank1",
            int'(lg_ba[base]), 1);
        base = n_log;
        do_req(1'b0, 2'd0, 12'd7, 9'd3, 1'b0);
        settle();
        chk(n_log - base == 1 && lg_cmd[base] == C_RD && lg_ba[base] == 2'd0,
            "R6 bank0 still hit", n_log - base, 1);
    endtask

    task automatic t_autopre();
        int base = n_log;
        do_req(1'b0, 2'd2, 12'd3, 9'd4, 1'b1);
        do_req(1'b0, 2'd2, 12'd3, 9'd5, 1'b0);
        settle();
        chk(lg_cmd[base+1] == C_RD && lg_addr[base+1] == 12'd1028, "R4 close flag on bit 10",
            int'(lg_addr[base+1]), 1028);
        chk(lg_cmd[base+2] == C_ACT, "R7 reactivate after close",
            int'(lg_cmd[base+2]), int'(C_ACT));
        chk(lg_cyc[base+2] - lg_cyc[base+1] == 4, "R7 close gap",
            lg_cyc[base+2] - lg_cyc[base+1], 4);
    endtask

    task automatic t_burst();
        int base;
        cfg_burst = 2'd3;
        base = n_log;
        do_req(1'b0, 2'd1, 12'd9, 9'd10, 1'b0);
        do_req(1'b1, 2'd1, 12'd9, 9'd11, 1'b0);
        settle();
        chk(lg_cyc[base+1] - lg_cyc[base] == 4, "R8 burst 8 spacing",
            lg_cyc[base+1] - lg_cyc[base], 4);
        chk(lg_cmd[base+1] == C_WR, "R8 second is write", int'(lg_cmd[base+1]), int'(C_WR));
        cfg_burst = 2'd1;
        base = n_log;
        do_req(1'b0, 2'd1, 12'd9, 9'd12, 1'b0);
        do_req(1'b0, 2'd1, 12'd9, 9'd13, 1'b0);
        settle();
        chk(lg_cyc[base+1] - lg_cyc[base] == 1, "R8 burst 2 spacing",
            lg_cyc[base+1] - lg_cyc[base], 1);
        cfg_burst = 2'd2;
        base = n_log;
        do_req(1'b0, 2'd1, 12'd9, 9'd14, 1'b0);
        do_req(1'b0, 2'd1, 12'd9, 9'd15, 1'b0);
        settle();
        chk(lg_cyc[base+1] - lg_cyc[base] == 2, "R8 burst 4 spacing",
            lg_cyc[base+1] - lg_cyc[base], 2);
    endtask

    task automatic t_ref_priority();
        int base, r0;
        cfg_burst = 2'd3;
        base = n_log;
        do_req(1'b0, 2'd1, 12'd9, 9'd20, 1'b0);
        r0 = n_ref;
        cfg_ref_interval = 16'd2;
        fork
            do_req(1'b0, 2'd0, 12'd7, 9'd6, 1'b0);
            begin
                for (int i = 0; i < 100 && n_ref == r0; i++) @(negedge clk);
                cfg_ref_interval = 16'd60000;
            end
        join
        settle();
        chk(lg_cmd[base+1] == C_PRE && lg_addr[base+1][10] == 1'b1,
            "R10 refresh before request", int'(lg_cmd[base+1]), int'(C_PRE));
        chk(lg_cyc[base+1] - lg_cyc[base] == 4, "R10 after burst", 
            lg_cyc[base+1] - lg_cyc[base], 4);
        chk(lg_cmd[base+2] == C_REF, "R9 refresh code", int'(lg_cmd[base+2]), int'(C_REF));
        chk(lg_cyc[base+2] - lg_cyc[base+1] == 2, "R9 precharge-all gap",
            lg_cyc[base+2] - lg_cyc[base+1], 2);
        chk(lg_cmd[base+3] == C_ACT && lg_ba[base+3] == 2'd0, "R9 banks idle after refresh",
            int'(lg_cmd[base+3]), int'(C_ACT));
        chk(lg_cyc[base+3] - lg_cyc[base+2] == 5, "R9 rfc gap",
            lg_cyc[base+3] - lg_cyc[base+2], 5);
        chk(lg_cmd[base+4] == C_RD, "R10 request served later",
            int'(lg_cmd[base+4]), int'(C_RD));
        cfg_burst = 2'd2;
    endtask

    task automatic t_ref_idle();
        int base, r0;
        do_req(1'b0, 2'd0, 12'd7, 9'd1, 1'b1);
        settle();
        base = n_log;
        r0 = n_ref;
        cfg_ref_interval = 16'd2;
        for (int i = 0; i < 100 && n_ref == r0; i++) @(negedge clk);
        cfg_ref_interval = 16'd60000;
        settle();
        chk(n_log - base == 1 && lg_cmd[base] == C_REF, "R9 idle refresh without precharge",
            int'(lg_cmd[base]), int'(C_REF));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_closed_bank();
        t_hit();
        t_miss();
        t_banks();
        t_autopre();
        t_burst();
        t_ref_priority();
        t_ref_idle();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

endmodule